// File: doc/BRIEF.md
# Processor Low-Power Mode Controller

This block moves a CPU core between three operating states: normal execution, light sleep and deep sleep. The instruction decoder raises a one-cycle sleep strobe. The block samples that strobe together with two control-register bits, a standby enable and a deep-sleep select, and picks the target state from them. While the core sleeps, the block drives the halt line to the CPU and the enables for the peripheral clock, the DMA controller and the external bus (bus access and refresh). It also drives a two-bit status code that board logic can watch.

An NMI, a non-zero external interrupt level or any peripheral interrupt line brings the core back to normal execution. The interrupt mask bit of the core's status register has no effect on this. On such a wake the block gives a one-cycle exception-start pulse and latches an event code that identifies the source. Any of four reset sources also ends a low-power state and returns every enable to its running value. The four sources are the power-on pin, the manual-reset pin, a watchdog power-on overflow and a watchdog manual overflow. A sleep strobe with standby enabled is not handled here. It only produces a one-cycle standby-request pulse for the clock-stopping logic.

Top module: `lpm_ctrl`

## Requirements
- R1: A sleep strobe in normal execution with standby 0 and deep-select 0 enters light sleep on the next cycle: halt 1, peripheral clock enable 1, DMA enable 1, bus enable 1.
- R2: A sleep strobe in normal execution with standby 0 and deep-select 1 enters deep sleep on the next cycle: halt 1, peripheral clock enable 1, DMA enable 0, bus enable 0.
- R3: The status output is 2'b10 in both sleep states and 2'b00 in normal execution. No other value ever appears.
- R4: In either sleep state, an interrupt (NMI high, external level non-zero, or any peripheral line high) returns the block to normal execution on the next cycle, with all enables at 1 and the exception-start output high for exactly that one cycle.
- R5: A wake by interrupt happens whatever the value of the interrupt mask input.
- R6: On an interrupt wake the event code is set to 0x1C0 for NMI, to 0x200 + 0x20*L for external level L, and to 0x400 + 0x20*i for peripheral line i. NMI has priority over the external level, and the external level has priority over peripheral lines; among peripheral lines the lowest index wins. The code is held until the next wake or reset.
- R7: Any of the four reset sources (power-on pin, manual pin, watchdog power-on, watchdog manual) returns the block to normal execution on the next cycle, with all enables at 1, the event code at 0 and no exception-start pulse. This applies in any state.
- R8: When a reset source and an interrupt arrive in the same cycle, the reset wins: no exception-start pulse, and the event code goes to 0.
- R9: A sleep strobe with standby 1 leaves the block in normal execution and raises the standby-request output for exactly one cycle.
- R10: In normal execution, interrupts change neither the event code nor the exception-start output. A sleep strobe while already sleeping changes nothing.
- R11: The synchronous block reset puts the block in normal execution with halt 0, all enables 1, status 00, both pulses 0 and event code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| sleep_req_i | input | 1 | One-cycle sleep strobe from the instruction decoder |
| stby_en_i | input | 1 | Control bit: standby enable |
| deep_sel_i | input | 1 | Control bit: deep-sleep select |
| nmi_i | input | 1 | Non-maskable interrupt |
| ext_lvl_i | input | IRL_W | External interrupt level, 0 means none |
| per_irq_i | input | PER_N | Peripheral interrupt lines |
| int_mask_i | input | 1 | Interrupt mask bit of the core status register (no effect on wake) |
| por_pin_i | input | 1 | Power-on reset from the reset pin |
| mrst_pin_i | input | 1 | Manual reset from the reset pin |
| wdt_por_i | input | 1 | Power-on reset from watchdog overflow |
| wdt_mrst_i | input | 1 | Manual reset from watchdog overflow |
| cpu_halt_o | output | 1 | Halts the CPU core |
| pclk_en_o | output | 1 | Peripheral clock enable |
| dma_en_o | output | 1 | DMA controller enable |
| bus_en_o | output | 1 | Bus access and refresh enable |
| status_o | output | 2 | Mode status code |
| exc_start_o | output | 1 | One-cycle pulse that starts interrupt exception handling |
| stby_req_o | output | 1 | One-cycle pulse forwarding a standby request |
| evt_code_o | output | CODE_W | Latched wake event code |

## Verification
The assertions check on every cycle the transitions that can be read from the ports. They cover entry into each sleep depth with its set of enables and the match between status code and halt. They also cover the one-cycle wake on interrupt, the NMI code, reset recovery and its priority over interrupts, the standby pulse, and the fact that interrupts have no effect during normal execution. Only the bench scenarios show the rest: the full source priority across the NMI, level and peripheral encodings, the mask bit having no effect, event codes being held over later sleeps, and a sleep strobe being ignored while already halted.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_LIGHT = 2'd1,
    ST_DEEP  = 2'd2
  } lpm_state_e;

  localparam logic [1:0] STAT_RUN  = 2'b00;
  localparam logic [1:0] STAT_LOWP = 2'b10;

  function automatic logic [1:0] status_of(input lpm_state_e s);
    return (s == ST_RUN) ? STAT_RUN : STAT_LOWP;
  endfunction

endpackage

// File: rtl/lpm_wake_enc.sv
module lpm_wake_enc #(
  parameter int IRL_W  = 4,
  parameter int PER_N  = 8,
  parameter int CODE_W = 12,
  parameter logic [CODE_W-1:0] NMI_CODE  = 12'h1C0,
  parameter logic [CODE_W-1:0] IRL_BASE  = 12'h200,
  parameter logic [CODE_W-1:0] PER_BASE  = 12'h400,
  parameter logic [CODE_W-1:0] CODE_STEP = 12'h020
) (
  input  logic              nmi_i,
  input  logic [IRL_W-1:0]  ext_lvl_i,
  input  logic [PER_N-1:0]  per_irq_i,
  output logic              irq_any_o,
  output logic [CODE_W-1:0] code_o
);

  localparam int PAD_W = CODE_W - IRL_W;

  logic [CODE_W-1:0] per_code [PER_N];
  logic [CODE_W-1:0] lvl_ext;
  logic [CODE_W-1:0] lvl_code;
  logic [CODE_W-1:0] per_sel;
  logic              lvl_hit;
  logic              per_hit;

  genvar g;
  generate
    for (g = 0; g < PER_N; g++) begin : g_per_code
      assign per_code[g] = PER_BASE + CODE_W'(g) * CODE_STEP;
    end
  endgenerate

  assign lvl_ext  = {{PAD_W{1'b0}}, ext_lvl_i};
  assign lvl_code = IRL_BASE + lvl_ext * CODE_STEP;
  assign lvl_hit  = |ext_lvl_i;
  assign per_hit  = |per_irq_i;

  always_comb begin
    per_sel = '0;
    for (int i = PER_N - 1; i >= 0; i--) begin
      if (per_irq_i[i]) per_sel = per_code[i];
    end
  end

  always_comb begin
    if (nmi_i)        code_o = NMI_CODE;
    else if (lvl_hit) code_o = lvl_code;
    else              code_o = per_sel;
  end

  assign irq_any_o = nmi_i | lvl_hit | per_hit;

endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sleep_req_i,
  input  logic       stby_en_i,
  input  logic       deep_sel_i,
  input  logic       irq_any_i,
  input  logic       rst_any_i,
  output lpm_state_e state_nxt_o,
  output logic       wake_irq_o,
  output logic       stby_hit_o
);

  lpm_state_e state_q;
  lpm_state_e state_d;

  always_comb begin
    state_d = state_q;
    if (rst_any_i) begin
      state_d = ST_RUN;
    end else begin
      case (state_q)
        ST_RUN: begin
          if (sleep_req_i && !stby_en_i)
            state_d = deep_sel_i ? ST_DEEP : ST_LIGHT;
        end
        ST_LIGHT, ST_DEEP: begin
          if (irq_any_i) state_d = ST_RUN;
        end
        default: state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_RUN;
    else     state_q <= state_d;
  end

  assign state_nxt_o = state_d;
  assign wake_irq_o  = (state_q != ST_RUN) && irq_any_i && !rst_any_i;
  assign stby_hit_o  = (state_q == ST_RUN) && sleep_req_i && stby_en_i && !rst_any_i;

endmodule

// File: rtl/lpm_out_reg.sv
module lpm_out_reg
  import lpm_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  lpm_state_e        state_nxt_i,
  input  logic              wake_irq_i,
  input  logic              stby_hit_i,
  input  logic              rst_any_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              cpu_halt_o,
  output logic              pclk_en_o,
  output logic              dma_en_o,
  output logic              bus_en_o,
  output logic [1:0]        status_o,
  output logic              exc_start_o,
  output logic              stby_req_o,
  output logic [CODE_W-1:0] evt_code_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_halt_o  <= 1'b0;
      pclk_en_o   <= 1'b1;
      dma_en_o    <= 1'b1;
      bus_en_o    <= 1'b1;
      status_o    <= STAT_RUN;
      exc_start_o <= 1'b0;
      stby_req_o  <= 1'b0;
    end else begin
      cpu_halt_o  <= (state_nxt_i != ST_RUN);
      pclk_en_o   <= 1'b1;
      dma_en_o    <= (state_nxt_i != ST_DEEP);
      bus_en_o    <= (state_nxt_i != ST_DEEP);
      status_o    <= status_of(state_nxt_i);
      exc_start_o <= wake_irq_i;
      stby_req_o  <= stby_hit_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || rst_any_i) evt_code_o <= '0;
    else if (wake_irq_i)  evt_code_o <= code_i;
  end

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int IRL_W  = 4,
  parameter int PER_N  = 8,
  parameter int CODE_W = 12,
  parameter logic [CODE_W-1:0] NMI_CODE  = 12'h1C0,
  parameter logic [CODE_W-1:0] IRL_BASE  = 12'h200,
  parameter logic [CODE_W-1:0] PER_BASE  = 12'h400,
  parameter logic [CODE_W-1:0] CODE_STEP = 12'h020
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep_req_i,
  input  logic              stby_en_i,
  input  logic              deep_sel_i,
  input  logic              nmi_i,
  input  logic [IRL_W-1:0]  ext_lvl_i,
  input  logic [PER_N-1:0]  per_irq_i,
  input  logic              int_mask_i,
  input  logic              por_pin_i,
  input  logic              mrst_pin_i,
  input  logic              wdt_por_i,
  input  logic              wdt_mrst_i,
  output logic              cpu_halt_o,
  output logic              pclk_en_o,
  output logic              dma_en_o,
  output logic              bus_en_o,
  output logic [1:0]        status_o,
  output logic              exc_start_o,
  output logic              stby_req_o,
  output logic [CODE_W-1:0] evt_code_o
);

  logic              rst_any;
  logic              irq_any;
  logic [CODE_W-1:0] wake_code;
  lpm_state_e        state_nxt;
  logic              wake_irq;
  logic              stby_hit;
  logic              unused_mask;

  // Wake acceptance does not look at the core's interrupt mask.
  assign unused_mask = int_mask_i;
  assign rst_any     = por_pin_i | mrst_pin_i | wdt_por_i | wdt_mrst_i;

  lpm_wake_enc #(
    .IRL_W(IRL_W), .PER_N(PER_N), .CODE_W(CODE_W),
    .NMI_CODE(NMI_CODE), .IRL_BASE(IRL_BASE),
    .PER_BASE(PER_BASE), .CODE_STEP(CODE_STEP)
  ) u_enc (
    .nmi_i     (nmi_i),
    .ext_lvl_i (ext_lvl_i),
    .per_irq_i (per_irq_i),
    .irq_any_o (irq_any),
    .code_o    (wake_code)
  );

  lpm_seq u_seq (
    .clk         (clk),
    .rst         (rst),
    .sleep_req_i (sleep_req_i),
    .stby_en_i   (stby_en_i),
    .deep_sel_i  (deep_sel_i),
    .irq_any_i   (irq_any),
    .rst_any_i   (rst_any),
    .state_nxt_o (state_nxt),
    .wake_irq_o  (wake_irq),
    .stby_hit_o  (stby_hit)
  );

  lpm_out_reg #(.CODE_W(CODE_W)) u_out (
    .clk         (clk),
    .rst         (rst),
    .state_nxt_i (state_nxt),
    .wake_irq_i  (wake_irq),
    .stby_hit_i  (stby_hit),
    .rst_any_i   (rst_any),
    .code_i      (wake_code),
    .cpu_halt_o  (cpu_halt_o),
    .pclk_en_o   (pclk_en_o),
    .dma_en_o    (dma_en_o),
    .bus_en_o    (bus_en_o),
    .status_o    (status_o),
    .exc_start_o (exc_start_o),
    .stby_req_o  (stby_req_o),
    .evt_code_o  (evt_code_o)
  );

endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
  parameter int IRL_W  = 4,
  parameter int PER_N  = 8,
  parameter int CODE_W = 12,
  parameter logic [CODE_W-1:0] NMI_CODE = 12'h1C0
) (
  input logic              clk,
  input logic              rst,
  input logic              sleep_req_i,
  input logic              stby_en_i,
  input logic              deep_sel_i,
  input logic              nmi_i,
  input logic [IRL_W-1:0]  ext_lvl_i,
  input logic [PER_N-1:0]  per_irq_i,
  input logic              por_pin_i,
  input logic              mrst_pin_i,
  input logic              wdt_por_i,
  input logic              wdt_mrst_i,
  input logic              cpu_halt_o,
  input logic              pclk_en_o,
  input logic              dma_en_o,
  input logic              bus_en_o,
  input logic [1:0]        status_o,
  input logic              exc_start_o,
  input logic              stby_req_o,
  input logic [CODE_W-1:0] evt_code_o
);

  logic rany;
  logic iany;
  assign rany = por_pin_i | mrst_pin_i | wdt_por_i | wdt_mrst_i;
  assign iany = nmi_i | (|ext_lvl_i) | (|per_irq_i);

  AST_STATUS_HALT: assert property (@(posedge clk) disable iff (rst)
    (status_o == 2'b00 && !cpu_halt_o) || (status_o == 2'b10 && cpu_halt_o)); // R3

  AST_LIGHT_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (!cpu_halt_o && sleep_req_i && !stby_en_i && !deep_sel_i && !rany)
    |=> (cpu_halt_o && pclk_en_o && dma_en_o && bus_en_o)); // R1

  AST_DEEP_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (!cpu_halt_o && sleep_req_i && !stby_en_i && deep_sel_i && !rany)
    |=> (cpu_halt_o && pclk_en_o && !dma_en_o && !bus_en_o)); // R2

  AST_IRQ_WAKE: assert property (@(posedge clk) disable iff (rst)
    (cpu_halt_o && iany && !rany)
    |=> (!cpu_halt_o && exc_start_o && dma_en_o && bus_en_o)); // R4

  AST_EXC_AFTER_HALT: assert property (@(posedge clk) disable iff (rst)
    exc_start_o |-> $past(cpu_halt_o)); // R4

  AST_NMI_CODE: assert property (@(posedge clk) disable iff (rst)
    (cpu_halt_o && nmi_i && !rany) |=> (evt_code_o == NMI_CODE)); // R6

  AST_RST_WAKE: assert property (@(posedge clk) disable iff (rst)
    rany |=> (!cpu_halt_o && dma_en_o && bus_en_o && evt_code_o == '0)); // R7

  AST_RST_PRIO: assert property (@(posedge clk) disable iff (rst)
    (rany && iany) |=> !exc_start_o); // R8

  AST_STBY_FWD: assert property (@(posedge clk) disable iff (rst)
    (!cpu_halt_o && sleep_req_i && stby_en_i && !rany)
    |=> (!cpu_halt_o && stby_req_o)); // R9

  AST_RUN_IRQ_IGN: assert property (@(posedge clk) disable iff (rst)
    (!cpu_halt_o && !sleep_req_i && iany && !rany)
    |=> (!exc_start_o && $stable(evt_code_o))); // R10

endmodule

bind lpm_ctrl lpm_ctrl_chk #(
  .IRL_W(IRL_W), .PER_N(PER_N), .CODE_W(CODE_W), .NMI_CODE(NMI_CODE)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sleep_req_i (sleep_req_i),
  .stby_en_i   (stby_en_i),
  .deep_sel_i  (deep_sel_i),
  .nmi_i       (nmi_i),
  .ext_lvl_i   (ext_lvl_i),
  .per_irq_i   (per_irq_i),
  .por_pin_i   (por_pin_i),
  .mrst_pin_i  (mrst_pin_i),
  .wdt_por_i   (wdt_por_i),
  .wdt_mrst_i  (wdt_mrst_i),
  .cpu_halt_o  (cpu_halt_o),
  .pclk_en_o   (pclk_en_o),
  .dma_en_o    (dma_en_o),
  .bus_en_o    (bus_en_o),
  .status_o    (status_o),
  .exc_start_o (exc_start_o),
  .stby_req_o  (stby_req_o),
  .evt_code_o  (evt_code_o)
);

// File: tb/lpm_ctrl_tb_top.sv
`timescale 1ns/1ps
module lpm_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sleep_req = 1'b0, stby_en = 1'b0, deep_sel = 1'b0, nmi = 1'b0;
  logic [3:0]  ext_lvl = 4'd0;
  logic [7:0]  per_irq = 8'd0;
  logic        int_mask = 1'b0;
  logic [3:0]  rsrc = 4'd0; // {wdt_mrst, wdt_por, mrst_pin, por_pin}
  logic        cpu_halt, pclk_en, dma_en, bus_en, exc_start, stby_req;
  logic [1:0]  status;
  logic [11:0] evt_code;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lpm_ctrl dut_i (
    .clk(clk), .rst(rst), .sleep_req_i(sleep_req), .stby_en_i(stby_en),
    .deep_sel_i(deep_sel), .nmi_i(nmi), .ext_lvl_i(ext_lvl), .per_irq_i(per_irq),
    .int_mask_i(int_mask), .por_pin_i(rsrc[0]), .mrst_pin_i(rsrc[1]),
    .wdt_por_i(rsrc[2]), .wdt_mrst_i(rsrc[3]), .cpu_halt_o(cpu_halt),
    .pclk_en_o(pclk_en), .dma_en_o(dma_en), .bus_en_o(bus_en), .status_o(status),
    .exc_start_o(exc_start), .stby_req_o(stby_req), .evt_code_o(evt_code)
  );

  // ctl = {halt, pclk, dma, bus, status[1:0], exc_start, stby_req}
  typedef struct packed {
    logic [7:0]  rq;
    logic        req, stby, dslp, nmi;
    logic [3:0]  lvl;
    logic [7:0]  per;
    logic        msk;
    logic [3:0]  rs;
    logic [7:0]  ctl;
    logic [11:0] code;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{8'd3,  1'b0,1'b0,1'b0,1'b0, 4'd0, 8'h00, 1'b0, 4'h0, 8'h70, 12'h000}, // R3 idle run
    '{8'd1,  1'b1,1'b0,1'b0,1'b0, 4'd0, 8'h00, 1'b0, 4'h0, 8'hF8, 12'h000}, // R1 light
    '{8'd3,  1'b0,1'b0,1'b0,1'b0, 4'd0, 8'h00, 1'b0, 4'h0, 8'hF8, 12'h000}, // R3 stays
    '{8'd10, 1'b1,1'b0,1'b1,1'b0, 4'd0, 8'h00, 1'b0, 4'h0, 8'hF8, 12'h000}, // R10 strobe while halted
    '{8'd5,  1'b0,1'b0,1'b0,1'b1, 4'd0, 8'h00, 1'b1, 4'h0, 8'h72, 12'h1C0}, // R5 NMI with mask set
    '{8'd4,  1'b0,1'b0,1'b0,1'b0, 4'd0, 8'h00, 1'b0, 4'h0, 8'h70, 12'h1C0}, // R4 pulse one cycle
    '{8'd10, 1'b0,1'b0,1'b0,1'b1, 4'd0, 8'h00, 1'b0, 4'h0, 8'h70, 12'h1C0}, // R10 NMI in run
    '{8'd2,  1'b1,1'b0,1'b1,1'b0, 4'd0, 8'h00, 1'b0, 4'h0, 8'hC8, 12'h1C0}, // R2 deep
    '{8'd6,  1'b0,1'b0,1'b0,1'b0, 4'd5, 8'h00, 1'b0, 4'h0, 8'h72, 12'h2A0}, // R6 level 5
    '{8'd1,  1'b1,1'b0,1'b0,1'b0, 4'd0, 8'h00, 1'b0, 4'h0, 8'hF8, 12'h2A0}, // R1
    '{8'd6,  1'b0,1'b0,1'b0,1'b0, 4'd0, 8'h24, 1'b0, 4'h0, 8'h72, 12'h440}, // R6 lowest periph 2
    '{8'd9,  1'b1,1'b1,1'b0,1'b0, 4'd0, 8'h00, 1'b0, 4'h0, 8'h71, 12'h440}, // R9 standby fwd
    '{8'd9,  1'b0,1'b0,1'b0,1'b0, 4'd0, 8'h00, 1'b0, 4'h0, 8'h70, 12'h440}, // R9 pulse ends
    '{8'd2,  1'b1,1'b0,1'b1,1'b0, 4'd0, 8'h00, 1'b0, 4'h0, 8'hC8, 12'h440}, // R2
    '{8'd6,  1'b0,1'b0,1'b0,1'b1, 4'd3, 8'h01, 1'b0, 4'h0, 8'h72, 12'h1C0}, // R6 NMI wins
    '{8'd2,  1'b1,1'b0,1'b1,1'b0, 4'd0, 8'h00, 1'b0, 4'h0, 8'hC8, 12'h1C0}, // R2
    '{8'd8,  1'b0,1'b0,1'b0,1'b0, 4'd9, 8'h00, 1'b0, 4'h1, 8'h70, 12'h000}, // R8 reset beats irq
    '{8'd1,  1'b1,1'b0,1'b0,1'b0, 4'd0, 8'h00, 1'b0, 4'h0, 8'hF8, 12'h000}, // R1
    '{8'd7,  1'b0,1'b0,1'b0,1'b0, 4'd0, 8'h00, 1'b0, 4'h8, 8'h70, 12'h000}, // R7 watchdog manual
    '{8'd2,  1'b1,1'b0,1'b1,1'b0, 4'd0, 8'h00, 1'b0, 4'h0, 8'hC8, 12'h000}, // R2
    '{8'd7,  1'b0,1'b0,1'b0,1'b0, 4'd0, 8'h00, 1'b0, 4'h2, 8'h70, 12'h000}, // R7 manual pin
    '{8'd1,  1'b1,1'b0,1'b0,1'b0, 4'd0, 8'h00, 1'b0, 4'h0, 8'hF8, 12'h000}, // R1
    '{8'd6,  1'b0,1'b0,1'b0,1'b0, 4'd0, 8'h80, 1'b1, 4'h0, 8'h72, 12'h4E0}, // R6 periph 7
    '{8'd7,  1'b0,1'b0,1'b0,1'b0, 4'd0, 8'h00, 1'b0, 4'h4, 8'h70, 12'h000}, // R7 watchdog POR clears code
    '{8'd9,  1'b1,1'b1,1'b1,1'b0, 4'd0, 8'h00, 1'b0, 4'h0, 8'h71, 12'h000}  // R9 deep-select ignored
  };

  task automatic check(input int rq, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d actual=%h expected=%h at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] ctl_now();
    return {cpu_halt, pclk_en, dma_en, bus_en, status, exc_start, stby_req};
  endfunction

  task automatic drive_idle();
    sleep_req = 1'b0; stby_en = 1'b0; deep_sel = 1'b0; nmi = 1'b0;
    ext_lvl = 4'd0; per_irq = 8'd0; int_mask = 1'b0; rsrc = 4'd0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R11: block reset state
    repeat (2) @(posedge clk);
    #1;
    check(11, {ctl_now(), evt_code}, {8'h70, 12'h000});
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      sleep_req = VEC[v].req; stby_en = VEC[v].stby; deep_sel = VEC[v].dslp;
      nmi = VEC[v].nmi; ext_lvl = VEC[v].lvl; per_irq = VEC[v].per;
      int_mask = VEC[v].msk; rsrc = VEC[v].rs;
      @(posedge clk);
      #1;
      check(int'(VEC[v].rq), {12'h000, ctl_now()}, {12'h000, VEC[v].ctl});
      check(int'(VEC[v].rq), {8'h00, evt_code}, {8'h00, VEC[v].code});
    end

    // R10: strobe while in deep sleep keeps the deep enables
    drive_idle(); sleep_req = 1'b1; deep_sel = 1'b1;
    @(posedge clk); #1;
    drive_idle(); sleep_req = 1'b1;
    @(posedge clk); #1;
    check(10, {12'h000, ctl_now()}, {12'h000, 8'hC8});

    // R11: block reset from deep sleep with a latched code
    drive_idle(); ext_lvl = 4'd1;
    @(posedge clk); #1;
    check(6, {8'h00, evt_code}, {8'h00, 12'h220});
    drive_idle(); sleep_req = 1'b1; deep_sel = 1'b1;
    @(posedge clk); #1;
    drive_idle(); rst = 1'b1;
    @(posedge clk); #1;
    check(11, {ctl_now(), evt_code}, {8'h70, 12'h000});
    rst = 1'b0;
    @(posedge clk); #1;
    check(11, {ctl_now(), evt_code}, {8'h70, 12'h000});

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule